// File: doc/BRIEF.md
# Lite UART Register Front-End

A bus-slave register block for a minimal UART. A host reaches four 32-bit word registers through a simple single-cycle bus: receive data, transmit data, status and control. Received bytes come in on a byte stream with a valid/ready handshake and are held in a small receive FIFO. A write to the transmit register sends the low byte of the write data out on a byte stream, and transmission is treated as immediate.

The block keeps live status flags and a sticky interrupt-pending flag. It drives one level interrupt, which is pending gated by an enable bit in control. Software can flush the receive FIFO by writing the control register. Bit timing, serial framing and parity are not part of this block.

Bus timing: a read or write is one cycle with `bus_en_i` high. Read data appears on `bus_rdata_o` after the next rising edge and holds until the next read. The word index is `bus_addr_i[3:2]`: 0 is RX data, 1 is TX data, 2 is status and 3 is control.

Top module: `lite_uart_regs`

## Requirements
- R1: After reset, status reads 0x00000004, control reads 0, `irq_o` and `tx_valid_o` are 0, and `rx_ready_o` is 1.
- R2: A read of word 0 returns the oldest buffered byte zero-extended to 32 bits and removes it. Bytes come out in arrival order, including across the wrap of the 3-bit write position.
- R3: While 8 bytes are buffered, `rx_ready_o` is 0 and status bit1 (RX full) is 1. A byte offered in that state is dropped and the contents are unchanged.
- R4: A read of word 0 while the FIFO is empty does not underflow. It returns the stale byte at the current write position, and status bit0 stays 0.
- R5: Status bit0 (RX valid) is 1 exactly when the FIFO is non-empty. Bit2 (TX empty) always reads 1. Bits 3, 5, 6, 7 and all bits above 7 read 0.
- R6: A write to word 1 drives `tx_valid_o` high for exactly the cycle after the write, with `tx_data_o` equal to `bus_wdata_i[7:0]`. A later read of word 1 returns the full 32-bit value last written.
- R7: Status bit4 (interrupt pending) is set by every write to word 1 and reads 1 while the FIFO is non-empty. A status read clears the flag set by a write to word 1, but bit4 stays 1 while data remains in the FIFO.
- R8: `irq_o` equals status bit4 AND control bit4 (interrupt enable).
- R9: A write to word 3 stores the full 32-bit value for readback. If bit1 of that value is set, the FIFO is emptied: write position and count return to 0.
- R10: Writes to word 2 (status) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | FIFO can accept a byte |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte valid, one cycle per TX write |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data, the `tx_valid_o` pulse and FIFO occupancy are all registered at the access edge. The bench drives each access on a falling edge and samples the result at the next falling edge, half a cycle after the edge that registered it. `irq_o` and `rx_ready_o` are combinational from registered state, so they are also due at that falling edge after the access or push. The one-cycle width of the TX pulse is checked one further falling edge later. The FIFO wrap, the full-state drop and the stale read on an empty FIFO are set up by directed sequences. The bench predicts each result from the push and pop order it applied.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
  localparam int WORD_W    = 32;
  localparam int BUS_ADDR_W = 4;

  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_idx_e;

  // status bit positions
  localparam int ST_RX_VALID = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_PEND     = 4;

  // control bit positions
  localparam int CT_RST_RX = 1;
  localparam int CT_IE     = 4;
endpackage

// File: rtl/lite_uart_rx_fifo.sv
module lite_uart_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [BYTE_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ready_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  rd_idx;
  logic [DEPTH-1:0]  ent_we;
  logic              push_ok, pop_ok;

  assign ready_o = (cnt_q != CNT_W'(DEPTH));
  assign push_ok = push_i & ready_o & ~flush_i;
  assign pop_ok  = pop_i & (cnt_q != '0) & ~flush_i;
  // oldest entry sits count slots behind the write position
  assign rd_idx  = wptr_q - cnt_q[PTR_W-1:0];
  assign head_o  = mem_q[rd_idx];
  assign cnt_o   = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign ent_we[i] = push_ok && (wptr_q == PTR_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (ent_we[i]) mem_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/lite_uart_status.sv
module lite_uart_status
  import lite_uart_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic              stat_rd_i,
  input  logic              rx_nonempty_i,
  input  logic              rx_full_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic pend_q;
  logic pend_bit;

  // sticky part set by TX writes; FIFO data keeps the bit up on its own
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (tx_wr_i)   pend_q <= 1'b1;
    else if (stat_rd_i) pend_q <= 1'b0;
  end

  assign pend_bit = pend_q | rx_nonempty_i;

  always_comb begin
    status_o              = '0;
    status_o[ST_RX_VALID] = rx_nonempty_i;
    status_o[ST_RX_FULL]  = rx_full_i;
    status_o[ST_TX_EMPTY] = 1'b1;
    status_o[ST_PEND]     = pend_bit;
  end

  assign irq_o = pend_bit & irq_en_i;
endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
  import lite_uart_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_en_i,
  input  logic                  bus_we_i,
  input  logic [BUS_ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0]     bus_wdata_i,
  output logic [WORD_W-1:0]     bus_rdata_o,
  input  logic [BYTE_W-1:0]     rx_data_i,
  input  logic                  rx_valid_i,
  output logic                  rx_ready_o,
  output logic [BYTE_W-1:0]     tx_data_o,
  output logic                  tx_valid_o,
  output logic                  irq_o
);
  reg_idx_e            idx;
  logic                rd, wr;
  logic                rx_pop, tx_wr, ctrl_wr, stat_rd, rx_flush;
  logic [BYTE_W-1:0]   rx_head;
  logic [CNT_W-1:0]    rx_cnt;
  logic [WORD_W-1:0]   stat_word;
  logic [WORD_W-1:0]   ctrl_q, tx_q, rdata_q;
  logic [BYTE_W-1:0]   txd_q;
  logic                txv_q;
  logic [BUS_ADDR_W-3:0] unused_low;

  assign idx        = reg_idx_e'(bus_addr_i[3:2]);
  assign unused_low = bus_addr_i[1:0];
  assign rd         = bus_en_i & ~bus_we_i;
  assign wr         = bus_en_i & bus_we_i;
  assign rx_pop     = rd & (idx == REG_RX);
  assign stat_rd    = rd & (idx == REG_STAT);
  assign tx_wr      = wr & (idx == REG_TX);
  assign ctrl_wr    = wr & (idx == REG_CTRL);
  assign rx_flush   = ctrl_wr & bus_wdata_i[CT_RST_RX];

  lite_uart_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_valid_i),
    .push_data_i(rx_data_i),
    .pop_i      (rx_pop),
    .flush_i    (rx_flush),
    .head_o     (rx_head),
    .cnt_o      (rx_cnt),
    .ready_o    (rx_ready_o)
  );

  lite_uart_status #(.DATA_W(WORD_W)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_wr_i      (tx_wr),
    .stat_rd_i    (stat_rd),
    .rx_nonempty_i(rx_cnt != '0),
    .rx_full_i    (rx_cnt == CNT_W'(DEPTH)),
    .irq_en_i     (ctrl_q[CT_IE]),
    .status_o     (stat_word),
    .irq_o        (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tx_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata_i;
      if (tx_wr)   tx_q   <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      txv_q <= tx_wr;
      if (tx_wr) txd_q <= bus_wdata_i[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd) begin
      unique case (idx)
        REG_RX:   rdata_q <= WORD_W'(rx_head);
        REG_TX:   rdata_q <= tx_q;
        REG_STAT: rdata_q <= stat_word;
        REG_CTRL: rdata_q <= ctrl_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign tx_valid_o  = txv_q;
  assign tx_data_o   = txd_q;
endmodule

// File: rtl/lite_uart_regs_chk.sv
module lite_uart_regs_chk #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [3:0]        bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       stat_word
);
  logic rd_rx, wr_tx, wr_ctrl, wr_stat;
  assign rd_rx   = bus_en_i && !bus_we_i && bus_addr_i[3:2] == 2'd0;
  assign wr_tx   = bus_en_i &&  bus_we_i && bus_addr_i[3:2] == 2'd1;
  assign wr_stat = bus_en_i &&  bus_we_i && bus_addr_i[3:2] == 2'd2;
  assign wr_ctrl = bus_en_i &&  bus_we_i && bus_addr_i[3:2] == 2'd3;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CNT_W'(DEPTH));

  a_r3_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_o && rx_valid_i && !rd_rx && !wr_ctrl) |=> !rx_ready_o);

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == '0 && rd_rx && !rx_valid_i) |=> rx_cnt == '0);

  a_r6_tx_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> (tx_valid_o && tx_data_o == $past(bus_wdata_i[BYTE_W-1:0])));

  a_r6_tx_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tx |=> !tx_valid_o);

  a_r7_tx_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> stat_word[4]);

  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_q[4] && stat_word[4]));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && bus_wdata_i[1]) |=> rx_cnt == '0);

  a_r10_stat_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !rx_valid_i) |=> ($stable(rx_cnt) && $stable(ctrl_q)));
endmodule

bind lite_uart_regs lite_uart_regs_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_en_i   (bus_en_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o),
  .rx_cnt     (rx_cnt),
  .ctrl_q     (ctrl_q),
  .stat_word  (stat_word)
);

// File: tb/lite_uart_regs_tb_top.sv
`timescale 1ns/100ps
module lite_uart_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lite_uart_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .irq_o(irq)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  idx;
    logic [31:0] wd;
    logic        rchk;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 32'h0,         1'b1, 32'h0000_0004, 1'b0, 4'd1},  // R1
    '{1'b0, 2'd3, 32'h0,         1'b1, 32'h0000_0000, 1'b0, 4'd1},  // R1
    '{1'b1, 2'd3, 32'h0000_0091, 1'b0, 32'h0,         1'b0, 4'd9},  // R9
    '{1'b0, 2'd3, 32'h0,         1'b1, 32'h0000_0091, 1'b0, 4'd9},  // R9
    '{1'b1, 2'd1, 32'hDEAD_BE5A, 1'b0, 32'h0,         1'b1, 4'd6},  // R6
    '{1'b0, 2'd1, 32'h0,         1'b1, 32'hDEAD_BE5A, 1'b1, 4'd6},  // R6
    '{1'b0, 2'd2, 32'h0,         1'b1, 32'h0000_0014, 1'b0, 4'd7},  // R7
    '{1'b0, 2'd2, 32'h0,         1'b1, 32'h0000_0004, 1'b0, 4'd7},  // R7
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 4'd10}, // R10
    '{1'b0, 2'd2, 32'h0,         1'b1, 32'h0000_0004, 1'b0, 4'd10}, // R10
    '{1'b0, 2'd3, 32'h0,         1'b1, 32'h0000_0091, 1'b0, 4'd10}, // R10
    '{1'b1, 2'd3, 32'h0000_0000, 1'b0, 32'h0,         1'b0, 4'd9}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // access on one edge; result sampled at the following falling edge
  task automatic bus_op(input logic we, input logic [1:0] idx, input logic [31:0] wd);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = {idx, 2'b00}; bus_wdata = wd;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i].we, VEC[i].idx, VEC[i].wd);
      if (VEC[i].rchk) chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp);
      chk($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i].irq});
      if (VEC[i].we && VEC[i].idx == 2'd1) begin
        chk("R6 tx_valid", {31'b0, tx_valid}, 32'd1);
        chk("R6 tx_data", {24'b0, tx_data}, {24'b0, VEC[i].wd[7:0]});
      end
    end

    // R2 / R5: order and live status
    push(8'h11); push(8'h22); push(8'h33);
    bus_op(1'b0, 2'd2, 0); chk("R5 status nonempty", bus_rdata, 32'h15);
    chk("R8 irq disabled", {31'b0, irq}, 32'd0);
    bus_op(1'b0, 2'd0, 0); chk("R2 first", bus_rdata, 32'h11);
    bus_op(1'b0, 2'd0, 0); chk("R2 second", bus_rdata, 32'h22);
    bus_op(1'b0, 2'd0, 0); chk("R2 third", bus_rdata, 32'h33);
    bus_op(1'b0, 2'd2, 0); chk("R5 status empty", bus_rdata, 32'h04);

    // R3: fill across the wrap, refuse the ninth
    for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
    chk("R3 ready low", {31'b0, rx_ready}, 32'd0);
    bus_op(1'b0, 2'd2, 0); chk("R3 status full", bus_rdata, 32'h17);
    push(8'h99);
    bus_op(1'b0, 2'd2, 0); chk("R3 status after drop", bus_rdata, 32'h17);
    for (int i = 0; i < 8; i++) begin
      bus_op(1'b0, 2'd0, 0);
      chk($sformatf("R2 wrap byte%0d", i), bus_rdata, 32'h40 + i);
    end
    chk("R3 ready again", {31'b0, rx_ready}, 32'd1);

    // R4: empty read returns byte at write position (slot 3 = 0x40)
    bus_op(1'b0, 2'd0, 0); chk("R4 stale data", bus_rdata, 32'h40);
    bus_op(1'b0, 2'd2, 0); chk("R4 still empty", bus_rdata, 32'h04);

    // R8 / R7: enabled irq follows data; status read cannot clear it
    bus_op(1'b1, 2'd3, 32'h10);
    chk("R8 irq idle", {31'b0, irq}, 32'd0);
    push(8'h55);
    chk("R8 irq on data", {31'b0, irq}, 32'd1);
    bus_op(1'b0, 2'd2, 0); chk("R7 status with data", bus_rdata, 32'h15);
    chk("R7 irq kept by data", {31'b0, irq}, 32'd1);

    // R9: flush through control, enable retained
    bus_op(1'b1, 2'd3, 32'h12);
    chk("R9 irq after flush", {31'b0, irq}, 32'd0);
    bus_op(1'b0, 2'd2, 0); chk("R9 status after flush", bus_rdata, 32'h04);
    bus_op(1'b0, 2'd3, 0); chk("R9 ctrl readback", bus_rdata, 32'h12);

    // R6: one-cycle pulse, low byte only; R7 sticky pend
    bus_op(1'b1, 2'd1, 32'h0000_01FF);
    chk("R6 pulse", {31'b0, tx_valid}, 32'd1);
    chk("R6 low byte", {24'b0, tx_data}, 32'hFF);
    chk("R7 irq from tx", {31'b0, irq}, 32'd1);
    @(negedge clk);
    chk("R6 pulse ends", {31'b0, tx_valid}, 32'd0);
    chk("R7 pend sticky", {31'b0, irq}, 32'd1);
    bus_op(1'b0, 2'd2, 0); chk("R7 status pend", bus_rdata, 32'h14);
    chk("R7 cleared by read", {31'b0, irq}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule